// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs accesses to one external asynchronous memory or I/O bank on behalf of a simple internal requester. The requester presents an address, write data and a read/write flag with a valid strobe. The block accepts the request when it is idle. It then steps the external pins through a setup phase, a strobe phase and a recovery phase. The pins are chip select, output enable, write enable, address and data. For writes, the block ends the access with a one-cycle completion pulse. For reads, the pulse comes with the returned data.

Each phase has a programmable length, and every field adds its own fixed offset to the programmed value. Read setup adds nothing. Read strobe and write setup add one cycle. Write strobe adds two cycles. Recovery adds one cycle. Reads and writes therefore differ in length even when their fields hold the same values.

The chip-select level is configurable. An external wait input can stretch the strobe phase when that feature is enabled. The configured data width masks the unused data lanes. The block takes a snapshot of all configuration when it accepts a request, so later changes only affect the next request.

Top module: `smc_bank_ctrl`

## Requirements
- R1: After a read is accepted, chip select is active and output enable stays high for exactly `cfg_rd_setup` cycles (0 to 15). Output enable then goes low.
- R2: On a read, output enable stays low for `cfg_rd_strobe` + 1 cycles (field 0 to 31) when no wait extension occurs.
- R3: After a write is accepted, chip select is active and write enable stays high for `cfg_wr_setup` + 1 cycles before write enable goes low.
- R4: On a write, write enable stays low for `cfg_wr_strobe` + 2 cycles when no wait extension occurs.
- R5: After the strobe phase ends, chip select, output enable and write enable are all inactive for `cfg_turn` + 1 cycles. During those cycles `req_ready` is low. `req_ready` is high again in the cycle after the last one.
- R6: Chip select is active high when `cfg_cs_high` = 1 and active low when it is 0. While idle, the inactive level follows the live `cfg_cs_high` value.
- R7: When `cfg_wait_en` = 1, a high `mem_wait` in the final strobe cycle keeps the strobe phase going for one more cycle. When `cfg_wait_en` = 0, `mem_wait` has no effect on any output.
- R8: `done` is high for exactly one cycle, which is the last cycle of the strobe phase. On a read, `rdata` in that cycle equals `mem_dq_i` masked to the configured width. At all other times `rdata` is zero.
- R9: Width code `cfg_width` selects the data width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. On a write, `mem_dq_o` carries the write data masked to that width. `mem_dq_oe` is high through the setup and strobe phases of writes only.
- R10: Configuration, address and write data are captured when a request is accepted. Changing the configuration during an access does not alter that access.
- R11: Out of reset the block is idle: `req_ready` = 1, output enable and write enable are high, chip select is inactive, and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_high | input | 1 | Chip-select polarity (1 = active high) |
| cfg_wait_en | input | 1 | Enable stretching of the strobe by `mem_wait` |
| cfg_rd_setup | input | 4 | Read setup cycles |
| cfg_rd_strobe | input | 5 | Read strobe field (length = value + 1) |
| cfg_wr_setup | input | 4 | Write setup field (length = value + 1) |
| cfg_wr_strobe | input | 5 | Write strobe field (length = value + 2) |
| cfg_turn | input | 4 | Recovery field (length = value + 1) |
| cfg_width | input | 2 | Data width code |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle and accepting a request |
| done | output | 1 | Access completion pulse |
| rdata | output | DATA_W | Read data, valid with `done` on reads |
| mem_cs | output | 1 | Chip select, polarity per `cfg_cs_high` |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_dq_o | output | DATA_W | Data pins driven on writes |
| mem_dq_oe | output | 1 | Data pin drive enable |
| mem_dq_i | input | DATA_W | Data pins sampled on reads |
| mem_wait | input | 1 | External wait request |

## Verification
A request counts as accepted at the rising edge where `req_valid` and `req_ready` are both high, and that edge is cycle 0. Chip select becomes active in cycle 1. The strobe begins in cycle S+1, and `done` falls in cycle S+P+E, where E is the number of wait-extended cycles. Recovery covers the following T cycles, and `req_ready` returns in the cycle after them. Every pin and `rdata` are combinational from registered state and the live inputs. A behavioural model therefore advances on each rising edge, and its expectations are compared against the pins at the falling edge of the same cycle. Each access also compares its measured cycle-of-`done` against S+P+E worked out from the configuration that was applied at acceptance.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_TURN   = 2'd3
  } smc_phase_e;

  typedef struct packed {
    logic       cs_high;
    logic       wait_en;
    logic [3:0] rd_setup;
    logic [4:0] rd_strobe;
    logic [3:0] wr_setup;
    logic [4:0] wr_strobe;
    logic [3:0] turn;
    logic [1:0] width;
  } smc_cfg_t;

  // Setup phase length in cycles: reads +0, writes +1.
  function automatic logic [CNT_W-1:0] setup_len(input smc_cfg_t c, input logic wr);
    return wr ? CNT_W'(c.wr_setup) + CNT_W'(1) : CNT_W'(c.rd_setup);
  endfunction

  // Strobe phase length in cycles: reads +1, writes +2.
  function automatic logic [CNT_W-1:0] strobe_len(input smc_cfg_t c, input logic wr);
    return wr ? CNT_W'(c.wr_strobe) + CNT_W'(2) : CNT_W'(c.rd_strobe) + CNT_W'(1);
  endfunction

  // Recovery length in cycles: +1.
  function automatic logic [CNT_W-1:0] turn_len(input smc_cfg_t c);
    return CNT_W'(c.turn) + CNT_W'(1);
  endfunction

  // Lane mask for a width code: 0 -> 8, 1 -> 16, otherwise 32 bits.
  function automatic logic [31:0] lane_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/smc_down_cnt.sv
module smc_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/smc_snap.sv
module smc_snap
  import smc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  smc_cfg_t          cfg_in,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output smc_cfg_t          cfg_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      cfg_q   <= cfg_in;
      wr_q    <= wr_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  smc_cfg_t         cfg_now,
  input  smc_cfg_t         cfg_lat,
  input  logic             wr_lat,
  input  logic             cnt_zero,
  input  logic             mem_wait,
  output smc_phase_e       phase,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec,
  output logic             last_strobe,
  output logic             hold
);
  smc_phase_e ph_q, ph_d;
  logic [CNT_W-1:0] su_now, sb_now;

  assign phase       = ph_q;
  assign accept      = (ph_q == PH_IDLE) && req_valid;
  assign su_now      = setup_len(cfg_now, req_write);
  assign sb_now      = strobe_len(cfg_now, req_write);
  assign hold        = (ph_q == PH_STROBE) && cnt_zero && cfg_lat.wait_en && mem_wait;
  assign last_strobe = (ph_q == PH_STROBE) && cnt_zero && !hold;

  always_comb begin
    ph_d     = ph_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        cnt_load = 1'b1;
        if (su_now == '0) begin
          ph_d    = PH_STROBE;
          cnt_val = sb_now - CNT_W'(1);
        end else begin
          ph_d    = PH_SETUP;
          cnt_val = su_now - CNT_W'(1);
        end
      end
      PH_SETUP: if (cnt_zero) begin
        ph_d     = PH_STROBE;
        cnt_load = 1'b1;
        cnt_val  = strobe_len(cfg_lat, wr_lat) - CNT_W'(1);
      end else cnt_dec = 1'b1;
      PH_STROBE: if (last_strobe) begin
        ph_d     = PH_TURN;
        cnt_load = 1'b1;
        cnt_val  = turn_len(cfg_lat) - CNT_W'(1);
      end else cnt_dec = 1'b1;
      PH_TURN: if (cnt_zero) ph_d = PH_IDLE;
               else cnt_dec = 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // R8: completion is a single-cycle event.
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    last_strobe |=> !last_strobe);
  // R7: a wait hold keeps the strobe phase for the next cycle.
  a_r7_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ph_q == PH_STROBE));
  // R5: the strobe is always followed by recovery, never straight by idle.
  a_r5_turn_follows: assert property (@(posedge clk) disable iff (!rst_n)
    last_strobe |=> (ph_q == PH_TURN));
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cs_high,
  input  logic              cfg_wait_en,
  input  logic [3:0]        cfg_rd_setup,
  input  logic [4:0]        cfg_rd_strobe,
  input  logic [3:0]        cfg_wr_setup,
  input  logic [4:0]        cfg_wr_strobe,
  input  logic [3:0]        cfg_turn,
  input  logic [1:0]        cfg_width,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_wait
);
  smc_cfg_t         cfg_now, cfg_lat;
  logic             wr_lat, accept, cnt_load, cnt_dec, cnt_zero, last_strobe, hold;
  logic [CNT_W-1:0] cnt_val;
  logic [DATA_W-1:0] wdata_lat, mask;
  smc_phase_e       phase;
  logic             in_access, in_strobe, cs_pol;

  assign cfg_now = '{cs_high: cfg_cs_high, wait_en: cfg_wait_en,
                     rd_setup: cfg_rd_setup, rd_strobe: cfg_rd_strobe,
                     wr_setup: cfg_wr_setup, wr_strobe: cfg_wr_strobe,
                     turn: cfg_turn, width: cfg_width};

  smc_snap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .take(accept), .cfg_in(cfg_now),
    .wr_in(req_write), .addr_in(req_addr), .wdata_in(req_wdata),
    .cfg_q(cfg_lat), .wr_q(wr_lat), .addr_q(mem_addr), .wdata_q(wdata_lat));

  smc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cfg_now(cfg_now), .cfg_lat(cfg_lat), .wr_lat(wr_lat), .cnt_zero(cnt_zero),
    .mem_wait(mem_wait), .phase(phase), .accept(accept), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .cnt_dec(cnt_dec), .last_strobe(last_strobe), .hold(hold));

  smc_down_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero));

  assign mask      = lane_mask(cfg_lat.width)[DATA_W-1:0];
  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign in_strobe = (phase == PH_STROBE);
  assign cs_pol    = (phase == PH_IDLE) ? cfg_cs_high : cfg_lat.cs_high;

  assign req_ready = (phase == PH_IDLE);
  assign done      = last_strobe;
  assign rdata     = (last_strobe && !wr_lat) ? (mem_dq_i & mask) : '0;
  assign mem_cs    = in_access ? cs_pol : !cs_pol;
  assign mem_oe_n  = !(in_strobe && !wr_lat);
  assign mem_we_n  = !(in_strobe && wr_lat);
  assign mem_dq_oe = in_access && wr_lat;
  assign mem_dq_o  = wdata_lat & mask;

  // R2/R4: the two strobes never overlap.
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  // R10: the snapshot is frozen while an access runs.
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ((phase == PH_IDLE) || $stable(cfg_lat)));
  // R5: nothing is strobed and ready is low during recovery.
  a_r5_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> (mem_oe_n && mem_we_n && !req_ready && !mem_dq_oe));
endmodule

// File: tb/smc_bank_ctrl_bench.sv
module smc_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_high = 0, wait_en = 0;
  logic [3:0] rd_su = 0, wr_su = 0, turn = 0;
  logic [4:0] rd_sb = 0, wr_sb = 0;
  logic [1:0] width = 2;
  logic req_valid = 0, req_write = 0, mem_wait = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, dq_i = 32'h1357_9BDF;
  logic ready, done, cs, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_o;
  logic [AW-1:0] maddr;

  int vectors = 0, errors = 0;

  smc_bank_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_smc_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_cs_high(cs_high), .cfg_wait_en(wait_en),
    .cfg_rd_setup(rd_su), .cfg_rd_strobe(rd_sb), .cfg_wr_setup(wr_su),
    .cfg_wr_strobe(wr_sb), .cfg_turn(turn), .cfg_width(width),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(ready), .done(done), .rdata(rdata),
    .mem_cs(cs), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_addr(maddr),
    .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i), .mem_wait(mem_wait));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) dq_i <= {dq_i[30:0], dq_i[31] ^ dq_i[21] ^ dq_i[1] ^ dq_i[0]};

  // Behavioural reference: 0 idle, 1 in access, 2 recovery; t counts cycles.
  int m_st = 0, m_t = 0, m_s = 0, m_p = 0, m_turn = 0;
  bit m_we = 0, m_pol = 0, m_wen = 0;
  int m_w = 2;
  logic [AW-1:0] m_addr = 0;
  logic [DW-1:0] m_wd = 0;

  function automatic logic [DW-1:0] bits_for(int w);
    int n;
    n = (w == 0) ? 8 : (w == 1) ? 16 : 32;
    return (n == 32) ? '1 : ((DW'(1) << n) - DW'(1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_t <= 0;
    end else if (m_st == 0) begin
      if (req_valid) begin
        m_st <= 1; m_t <= 1; m_we <= req_write; m_pol <= cs_high; m_wen <= wait_en;
        m_s <= req_write ? int'(wr_su) + 1 : int'(rd_su);
        m_p <= req_write ? int'(wr_sb) + 2 : int'(rd_sb) + 1;
        m_turn <= int'(turn) + 1; m_w <= int'(width);
        m_addr <= req_addr; m_wd <= req_wdata;
      end
    end else if (m_st == 1) begin
      if (m_t >= m_s + m_p) begin
        if (!(m_wen && mem_wait)) begin m_st <= 2; m_t <= 1; end
      end else m_t <= m_t + 1;
    end else begin
      if (m_t >= m_turn) m_st <= 0; else m_t <= m_t + 1;
    end
  end

  task automatic cmp(string req, string nm, logic [DW-1:0] act, logic [DW-1:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit act_acc, strobe, e_done;
    logic pol;
    act_acc = (m_st == 1);
    strobe  = act_acc && (m_t > m_s);
    e_done  = act_acc && (m_t >= m_s + m_p) && !(m_wen && mem_wait);
    pol     = (m_st == 0) ? cs_high : m_pol;
    vectors++;
    cmp("R6", "mem_cs", DW'(cs), DW'(act_acc ? pol : !pol));
    cmp("R1 R2", "mem_oe_n", DW'(oe_n), DW'(!(strobe && !m_we)));
    cmp("R3 R4", "mem_we_n", DW'(we_n), DW'(!(strobe && m_we)));
    cmp("R8", "done", DW'(done), DW'(e_done));
    cmp("R5", "req_ready", DW'(ready), DW'(m_st == 0));
    cmp("R9", "mem_dq_oe", DW'(dq_oe), DW'(act_acc && m_we));
    cmp("R8", "rdata", rdata, (e_done && !m_we) ? (dq_i & bits_for(m_w)) : '0);
    if (act_acc) cmp("R10", "mem_addr", DW'(maddr), DW'(m_addr));
    if (act_acc && m_we) cmp("R9", "mem_dq_o", dq_o, m_wd & bits_for(m_w));
  end

  // One access; wait_n cycles of mem_wait after acceptance; scramble changes cfg mid-access.
  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, int wait_n, bit scramble);
    bit r;
    int s, p, t, lat;
    s = wr ? int'(wr_su) + 1 : int'(rd_su);
    p = wr ? int'(wr_sb) + 2 : int'(rd_sb) + 1;
    lat = s + p;
    if (wait_en && wait_n + 1 > lat) lat = wait_n + 1;  // R7 extension
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1;
    do begin @(negedge clk); r = ready; @(posedge clk); end while (!r);
    #1 req_valid = 0; mem_wait = (wait_n > 0);
    t = 1;
    if (scramble) begin
      cs_high = ~cs_high; wait_en = ~wait_en; rd_su = rd_su + 3; rd_sb = rd_sb + 7;
      wr_su = wr_su + 5; wr_sb = wr_sb + 2; turn = turn + 4; width = width + 1;
    end
    forever begin
      @(negedge clk);
      if (done) break;
      if (t > 200) break;
      @(posedge clk); #1; t++;
      if (t > wait_n) mem_wait = 0;
    end
    vectors++;
    if (t != lat) begin
      errors++;
      $display("FAIL R7 R10 latency: actual %0d expected %0d", t, lat);
    end
    mem_wait = 0;
    do @(negedge clk); while (!ready);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;  // R11 reset state
    if (!(ready && oe_n && we_n && cs == 1'b1 && !done)) begin
      errors++;
      $display("FAIL R11 reset: actual rdy%b oe%b we%b cs%b dn%b expected 1 1 1 1 0",
               ready, oe_n, we_n, cs, done);
    end
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 R2 minimal read, R3 R4 minimal write
    access(0, 24'h000010, 0, 0, 0);
    access(1, 24'h000020, 32'hCAFEF00D, 0, 0);
    // longer fields, R5 recovery lengths
    rd_su = 3; rd_sb = 5; wr_su = 2; wr_sb = 4; turn = 5;
    access(0, 24'h123456, 0, 0, 0);
    access(1, 24'h654321, 32'hA5A5_5A5A, 0, 0);
    rd_su = 15; rd_sb = 31; wr_su = 15; wr_sb = 31; turn = 15;
    access(0, 24'hFFFFFF, 0, 0, 0);
    access(1, 24'h0000FF, 32'hFFFF_FFFF, 0, 0);
    // R6 high polarity, R9 widths
    cs_high = 1; rd_su = 1; rd_sb = 2; wr_su = 0; wr_sb = 1; turn = 0;
    width = 0; access(1, 24'h1, 32'h1234_5678, 0, 0); access(0, 24'h2, 0, 0, 0);
    width = 1; access(1, 24'h3, 32'h8765_4321, 0, 0); access(0, 24'h4, 0, 0, 0);
    width = 3; access(0, 24'h5, 0, 0, 0);
    // R7 wait enabled: stretched; disabled: ignored
    wait_en = 1; width = 2;
    access(0, 24'h6, 0, 10, 0);
    access(1, 24'h7, 32'h0BAD_BEEF, 8, 0);
    access(0, 24'h8, 0, 1, 0);
    wait_en = 0;
    access(0, 24'h9, 0, 12, 0);
    access(1, 24'hA, 32'h1111_2222, 12, 0);
    // R10 configuration changed mid-access
    access(0, 24'hB, 0, 0, 1);
    access(1, 24'hC, 32'h3333_4444, 0, 1);
    access(0, 24'hD, 0, 3, 1);
    // back-to-back with zero recovery
    turn = 0; cs_high = 0; wait_en = 0; rd_su = 0; rd_sb = 0;
    for (int i = 0; i < 4; i++) access(i[0], AW'(i * 17), DW'(i * 32'h0101_0101), 0, 0);
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule